// File: doc/BRIEF.md
# Dark Level Compensation Filter

This block removes the dark offset from a stream of raw 10-bit pixel samples. Each frame carries a group of optical-black reference samples, marked by a flag, ahead of its active samples, and is bracketed by one-cycle frame-start and frame-end strobes. The block adds up the first 1024 reference samples of a frame and turns the sum into an average with four fractional bits. It then folds that average into a running dark estimate through a first-order recursive filter with two programmable coefficients.

The estimate is subtracted from every active sample of the following frames, and a signed user offset then sets the target black level. Four trigger modes decide which frames may update the estimate: a run of one to four frames after enabling, a change of the shutter setting, a change of the gain setting, or every frame. When no mode is enabled, compensation is off and the offset input instead acts as a plain unsigned pedestal that is subtracted. Active samples come out one clock later, clamped to 0..1023, with a valid flag.

Top module: `dlc_filter_top`

## Requirements
- R1: After reset, pix_valid_o is 0, pix_o is 0, and the dark estimate and the stored previous average are both 0.
- R2: Only valid samples with ob_flag_i set and only the first 1024 of them in a frame are summed. The new average OBnew is the sum shifted right by 6, giving 10 integer and 4 fraction bits. A frame with fewer than 1024 reference samples never updates the estimate.
- R3: On an update the estimate becomes A*(OBold+OBnew) + B*Dold, with products truncated and the result saturated at 16383 (1023.9375). coef_a_i encodes A as 0=0, 1=1/2, 2=1/4, 3=1/8. coef_b_i encodes B as 0=0, 1=1/2, 2=3/4, 3=1. B=3/4 is computed as (3*Dold)>>2.
- R4: With ob_old_sel_i=0, OBold is the average stored at the previous update. With ob_old_sel_i=1, OBold equals OBnew. Every update stores OBnew as the new stored average.
- R5: mode_en_i[0] (run mode): at the first frame start that sees this bit set after it was clear, the frame updates and run_len_i is loaded as the count of further frames that update, so 1 to 4 frames update in total.
- R6: mode_en_i[1]: a frame updates when shutter_i at its frame start differs from the value seen at the previous frame start. The first frame start after reset never counts as a change.
- R7: mode_en_i[2]: a frame updates when gain_i at its frame start differs from the value seen at the previous frame start. The first frame start after reset never counts as a change.
- R8: mode_en_i[3] makes every frame update. The update decision is taken at frame start, and enabled modes combine by OR.
- R9: The update happens at frame end. The corrector takes the new estimate only at the next frame start. Each valid sample without ob_flag_i comes out on pix_o one clock later with pix_valid_o set. pix_valid_o is 0 in every other cycle.
- R10: With any mode enabled, the output is pix - floor(estimate) + s, where offset_i[7]=0 gives s=+offset_i[6:0] and offset_i[7]=1 gives s=-offset_i[6:0]. The result is clamped to 0..1023.
- R11: With mode_en_i=0, the output is pix - offset_i (8-bit unsigned), clamped at 0, and the estimate has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_i | input | 10 | Raw pixel sample |
| pix_valid_i | input | 1 | Sample valid |
| ob_flag_i | input | 1 | Sample is an optical-black reference |
| frame_start_i | input | 1 | One-cycle frame start strobe |
| frame_end_i | input | 1 | One-cycle frame end strobe |
| mode_en_i | input | 4 | Trigger enables: [0] run, [1] shutter change, [2] gain change, [3] every frame |
| run_len_i | input | 2 | Extra frames for run mode (0..3) |
| coef_a_i | input | 2 | Coefficient A code |
| coef_b_i | input | 2 | Coefficient B code |
| ob_old_sel_i | input | 1 | 1 forces OBold equal to OBnew |
| shutter_i | input | 13 | Shutter setting watched for changes |
| gain_i | input | 7 | Gain setting watched for changes |
| offset_i | input | 8 | Sign-magnitude target offset, or unsigned pedestal when compensation is off |
| pix_o | output | 10 | Corrected pixel |
| pix_valid_o | output | 1 | Corrected pixel valid |

## Verification
The properties assume that frame_start_i and frame_end_i never fall in the same cycle as each other or as a valid sample. They also assume that the trigger and coefficient settings change only between frames. The stimulus keeps to this by inserting idle cycles around every strobe and by changing configuration only after a frame end. Reference levels, active sample values, coefficient codes and offsets are drawn at random, with directed frames for short and overlong reference groups, saturation and clamping at both ends.

// File: rtl/dlc_pkg.sv
// Shared types for the dark level compensation filter.
// Assumes: coefficient codes are 2 bits wide and are decoded only inside the filter.
package dlc_pkg;
    typedef enum logic [1:0] {
        A_ZERO    = 2'd0,
        A_HALF    = 2'd1,
        A_QUARTER = 2'd2,
        A_EIGHTH  = 2'd3
    } coef_a_e;

    typedef enum logic [1:0] {
        B_ZERO  = 2'd0,
        B_HALF  = 2'd1,
        B_3QTR  = 2'd2,
        B_ONE   = 2'd3
    } coef_b_e;

    // bit positions of the trigger enables
    localparam int MODE_RUN   = 0;
    localparam int MODE_SHUT  = 1;
    localparam int MODE_GAIN  = 2;
    localparam int MODE_EVERY = 3;
endpackage

// File: rtl/dlc_ob_accum.sv
// Sums the first 2**CNT_LOG2 reference samples of a frame and flags when that many were seen.
// Assumes: frame_start clears the sum and never coincides with a sample.
module dlc_ob_accum #(
    parameter int PIX_W    = 10,
    parameter int CNT_LOG2 = 10,
    localparam int SUM_W   = PIX_W + CNT_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             sample_en,
    input  logic [PIX_W-1:0] pix,
    output logic [SUM_W-1:0] sum,
    output logic             full
);
    localparam int CNT_W = CNT_LOG2 + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << CNT_LOG2);

    logic [CNT_W-1:0] count;

    assign full = (count == CNT_MAX);

    // accumulate reference samples until the quota is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum   <= '0;
            count <= '0;
        end else if (frame_start) begin
            sum   <= '0;
            count <= '0;
        end else if (sample_en && !full) begin
            sum   <= sum + SUM_W'(pix);
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dlc_trigger.sv
// Decides at each frame start whether the coming frame may update the dark estimate.
// Assumes: settings are stable at the frame start strobe.
module dlc_trigger #(
    parameter int SHUT_W = 13,
    parameter int GAIN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [3:0]        mode_en,
    input  logic [1:0]        run_len,
    input  logic [SHUT_W-1:0] shutter,
    input  logic [GAIN_W-1:0] gain,
    output logic              upd_frame
);
    import dlc_pkg::*;

    logic              armed;
    logic              run_prev;
    logic [1:0]        run_left;
    logic [SHUT_W-1:0] shut_prev;
    logic [GAIN_W-1:0] gain_prev;
    logic              run_rise, run_hit, shut_chg, gain_chg;

    // combine the four trigger conditions for the frame that starts now
    always_comb begin
        run_rise = mode_en[MODE_RUN] && !run_prev;
        run_hit  = run_rise || (mode_en[MODE_RUN] && run_left != 2'd0);
        shut_chg = armed && (shutter != shut_prev);
        gain_chg = armed && (gain != gain_prev);
    end

    // latch previous settings, run counter and the frame decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            run_prev  <= 1'b0;
            run_left  <= 2'd0;
            shut_prev <= '0;
            gain_prev <= '0;
            upd_frame <= 1'b0;
        end else if (frame_start) begin
            armed     <= 1'b1;
            run_prev  <= mode_en[MODE_RUN];
            shut_prev <= shutter;
            gain_prev <= gain;
            if (run_rise)
                run_left <= run_len;
            else if (run_hit)
                run_left <= run_left - 2'd1;
            upd_frame <= run_hit
                       || (mode_en[MODE_SHUT] && shut_chg)
                       || (mode_en[MODE_GAIN] && gain_chg)
                       || mode_en[MODE_EVERY];
        end
    end
endmodule

// File: rtl/dlc_recursive.sv
// First-order recursive dark estimator in fixed point with FRAC_W fraction bits.
// Assumes: CNT_LOG2 >= FRAC_W; frame_end and frame_start never share a cycle.
module dlc_recursive #(
    parameter int PIX_W    = 10,
    parameter int FRAC_W   = 4,
    parameter int CNT_LOG2 = 10,
    localparam int DW      = PIX_W + FRAC_W,
    localparam int SUM_W   = PIX_W + CNT_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             upd_frame,
    input  logic             ob_full,
    input  logic [SUM_W-1:0] ob_sum,
    input  logic [1:0]       coef_a,
    input  logic [1:0]       coef_b,
    input  logic             ob_old_sel,
    output logic [DW-1:0]    dark_state,
    output logic [DW-1:0]    dark_use
);
    import dlc_pkg::*;

    localparam int SH = CNT_LOG2 - FRAC_W;
    localparam int TW = DW + 2;
    localparam logic [TW-1:0] DMAX = TW'((1 << DW) - 1);

    logic [DW-1:0] ob_new, ob_old, ob_old_eff;
    logic [TW-1:0] pair, a_term, b_term, total;
    logic [DW-1:0] d_next;

    // evaluate the filter equation from the current sum and state
    always_comb begin
        ob_new     = DW'(ob_sum >> SH);
        ob_old_eff = ob_old_sel ? ob_new : ob_old;
        pair       = TW'(ob_old_eff) + TW'(ob_new);
        case (coef_a_e'(coef_a))
            A_HALF:    a_term = pair >> 1;
            A_QUARTER: a_term = pair >> 2;
            A_EIGHTH:  a_term = pair >> 3;
            default:   a_term = '0;
        endcase
        case (coef_b_e'(coef_b))
            B_HALF:  b_term = TW'(dark_state) >> 1;
            B_3QTR:  b_term = (TW'(dark_state) + (TW'(dark_state) << 1)) >> 2;
            B_ONE:   b_term = TW'(dark_state);
            default: b_term = '0;
        endcase
        total  = a_term + b_term;
        d_next = (total > DMAX) ? DMAX[DW-1:0] : total[DW-1:0];
    end

    // commit an update at frame end, hand it to the corrector at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dark_state <= '0;
            ob_old     <= '0;
            dark_use   <= '0;
        end else begin
            if (frame_end && upd_frame && ob_full) begin
                dark_state <= d_next;
                ob_old     <= ob_new;
            end
            if (frame_start)
                dark_use <= dark_state;
        end
    end
endmodule

// File: rtl/dlc_corrector.sv
// Subtracts the dark estimate and applies the offset, clamping to the pixel range; one register stage.
// Assumes: offset is narrower than the pixel range.
module dlc_corrector #(
    parameter int PIX_W  = 10,
    parameter int FRAC_W = 4,
    parameter int OFS_W  = 8,
    localparam int DW    = PIX_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix,
    input  logic             pix_act,
    input  logic             comp_on,
    input  logic [OFS_W-1:0] offset,
    input  logic [DW-1:0]    dark_use,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_out_valid
);
    localparam int SW = PIX_W + 3;
    localparam logic signed [SW-1:0] PMAX = SW'((1 << PIX_W) - 1);

    logic [PIX_W-1:0]       dark_int;
    logic [OFS_W-2:0]       mag;
    logic signed [SW-1:0]   p_s, d_s, o_s, r_s;
    logic [PIX_W-1:0]       clamped;

    // form the corrected value in signed arithmetic and clamp it
    always_comb begin
        dark_int = PIX_W'(dark_use >> FRAC_W);
        mag      = offset[OFS_W-2:0];
        p_s      = $signed(SW'(pix));
        if (comp_on) begin
            d_s = $signed(SW'(dark_int));
            o_s = offset[OFS_W-1] ? -$signed(SW'(mag)) : $signed(SW'(mag));
        end else begin
            d_s = '0;
            o_s = -$signed(SW'(offset));
        end
        r_s = p_s - d_s + o_s;
        if (r_s < 0)
            clamped = '0;
        else if (r_s > PMAX)
            clamped = PMAX[PIX_W-1:0];
        else
            clamped = r_s[PIX_W-1:0];
    end

    // register the corrected active sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out       <= '0;
            pix_out_valid <= 1'b0;
        end else begin
            pix_out_valid <= pix_act;
            if (pix_act)
                pix_out <= clamped;
        end
    end
endmodule

// File: rtl/dlc_filter_top.sv
// Dark level compensation filter: reference accumulation, trigger logic, recursive estimate, correction.
// Assumes: strobes and samples are mutually exclusive in time; settings change between frames.
module dlc_filter_top #(
    parameter int PIX_W    = 10,
    parameter int FRAC_W   = 4,
    parameter int CNT_LOG2 = 10,
    parameter int SHUT_W   = 13,
    parameter int GAIN_W   = 7,
    parameter int OFS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              pix_valid_i,
    input  logic              ob_flag_i,
    input  logic              frame_start_i,
    input  logic              frame_end_i,
    input  logic [3:0]        mode_en_i,
    input  logic [1:0]        run_len_i,
    input  logic [1:0]        coef_a_i,
    input  logic [1:0]        coef_b_i,
    input  logic              ob_old_sel_i,
    input  logic [SHUT_W-1:0] shutter_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              pix_valid_o
);
    localparam int DW    = PIX_W + FRAC_W;
    localparam int SUM_W = PIX_W + CNT_LOG2;

    logic [SUM_W-1:0] ob_sum;
    logic             ob_full;
    logic             upd_frame;
    logic [DW-1:0]    dark_state;
    logic [DW-1:0]    dark_use;
    logic             comp_on;

    assign comp_on = |mode_en_i;

    dlc_ob_accum #(.PIX_W(PIX_W), .CNT_LOG2(CNT_LOG2)) accum_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start_i),
        .sample_en(pix_valid_i && ob_flag_i), .pix(pix_i),
        .sum(ob_sum), .full(ob_full)
    );

    dlc_trigger #(.SHUT_W(SHUT_W), .GAIN_W(GAIN_W)) trig_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start_i),
        .mode_en(mode_en_i), .run_len(run_len_i),
        .shutter(shutter_i), .gain(gain_i), .upd_frame(upd_frame)
    );

    dlc_recursive #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .CNT_LOG2(CNT_LOG2)) filt_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start_i),
        .frame_end(frame_end_i), .upd_frame(upd_frame), .ob_full(ob_full),
        .ob_sum(ob_sum), .coef_a(coef_a_i), .coef_b(coef_b_i),
        .ob_old_sel(ob_old_sel_i), .dark_state(dark_state), .dark_use(dark_use)
    );

    dlc_corrector #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W)) corr_i (
        .clk(clk), .rst_n(rst_n), .pix(pix_i),
        .pix_act(pix_valid_i && !ob_flag_i), .comp_on(comp_on),
        .offset(offset_i), .dark_use(dark_use),
        .pix_out(pix_o), .pix_out_valid(pix_valid_o)
    );
endmodule

// File: rtl/dlc_filter_chk.sv
// Temporal checks on the dark level compensation filter, attached by bind.
// Assumes: same input discipline as the top module.
module dlc_filter_chk #(
    parameter int PIX_W = 10,
    parameter int DW    = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIX_W-1:0] pix_i,
    input logic             pix_valid_i,
    input logic             ob_flag_i,
    input logic             frame_start_i,
    input logic             frame_end_i,
    input logic [3:0]       mode_en_i,
    input logic [1:0]       coef_a_i,
    input logic [1:0]       coef_b_i,
    input logic [PIX_W-1:0] pix_o,
    input logic             pix_valid_o,
    input logic [DW-1:0]    dark_state,
    input logic [DW-1:0]    dark_use
);
    // R9: an active sample yields a valid output one clock later
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && !ob_flag_i) |=> pix_valid_o);

    // R9: no output without an active sample
    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid_i && !ob_flag_i) |=> !pix_valid_o);

    // R9: the corrector's estimate changes only at frame start
    assert_use_only_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(dark_use));

    // R3: the filter state changes only at frame end
    assert_state_only_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(dark_state));

    // R3: A=0, B=1 leaves the estimate unchanged
    assert_hold_coefs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && coef_a_i == 2'd0 && coef_b_i == 2'd3) |=> $stable(dark_state));

    // R11: with compensation off the output never exceeds the input
    assert_pedestal_only_lowers_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en_i == 4'd0 && pix_valid_i && !ob_flag_i) |=> (pix_o <= $past(pix_i)));
endmodule

bind dlc_filter_top dlc_filter_chk #(.PIX_W(PIX_W), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .pix_valid_i(pix_valid_i),
    .ob_flag_i(ob_flag_i), .frame_start_i(frame_start_i), .frame_end_i(frame_end_i),
    .mode_en_i(mode_en_i), .coef_a_i(coef_a_i), .coef_b_i(coef_b_i),
    .pix_o(pix_o), .pix_valid_o(pix_valid_o),
    .dark_state(dark_state), .dark_use(dark_use)
);

// File: tb/dlc_filter_top_tb_top.sv
// Self-checking bench: random and directed frames against a behavioural model of the requirements.
module dlc_filter_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OB_N = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pix_i = '0;
    logic        pix_valid_i = 1'b0;
    logic        ob_flag_i = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        frame_end_i = 1'b0;
    logic [3:0]  mode_en_i = '0;
    logic [1:0]  run_len_i = '0;
    logic [1:0]  coef_a_i = '0;
    logic [1:0]  coef_b_i = '0;
    logic        ob_old_sel_i = 1'b0;
    logic [12:0] shutter_i = '0;
    logic [6:0]  gain_i = '0;
    logic [7:0]  offset_i = '0;
    logic [9:0]  pix_o;
    logic        pix_valid_o;

    dlc_filter_top dut_i (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .pix_valid_i(pix_valid_i),
        .ob_flag_i(ob_flag_i), .frame_start_i(frame_start_i), .frame_end_i(frame_end_i),
        .mode_en_i(mode_en_i), .run_len_i(run_len_i), .coef_a_i(coef_a_i),
        .coef_b_i(coef_b_i), .ob_old_sel_i(ob_old_sel_i), .shutter_i(shutter_i),
        .gain_i(gain_i), .offset_i(offset_i), .pix_o(pix_o), .pix_valid_o(pix_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";

    // model state
    int m_state = 0, m_old = 0, m_use = 0, m_sum = 0, m_cnt = 0;
    bit m_upd = 0, m_armed = 0, m_run_prev = 0;
    int m_run_left = 0, m_shut_prev = 0, m_gain_prev = 0;

    task automatic check(string t, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    function automatic int expect_pix(int p);
        int r;
        if (mode_en_i != 0) begin
            r = p - (m_use >> 4);
            if (offset_i[7]) r = r - int'(offset_i[6:0]);
            else             r = r + int'(offset_i[6:0]);
        end else begin
            r = p - int'(offset_i);
        end
        if (r < 0) r = 0;
        if (r > 1023) r = 1023;
        return r;
    endfunction

    function automatic int filter_next(int sum);
        int ob_new, ob_old_eff, pair, a_t, b_t, tot;
        ob_new = sum >> 6;
        ob_old_eff = ob_old_sel_i ? ob_new : m_old;
        pair = ob_old_eff + ob_new;
        case (coef_a_i)
            2'd1: a_t = pair >> 1;
            2'd2: a_t = pair >> 2;
            2'd3: a_t = pair >> 3;
            default: a_t = 0;
        endcase
        case (coef_b_i)
            2'd1: b_t = m_state >> 1;
            2'd2: b_t = (3 * m_state) >> 2;
            2'd3: b_t = m_state;
            default: b_t = 0;
        endcase
        tot = a_t + b_t;
        if (tot > 16383) tot = 16383;
        return tot;
    endfunction

    task automatic start_frame();
        bit hit, sch, gch;
        @(negedge clk);
        pix_valid_i = 0; ob_flag_i = 0; frame_end_i = 0;
        frame_start_i = 1;
        hit = 0;
        if (mode_en_i[0] && !m_run_prev) begin
            m_run_left = run_len_i; hit = 1;
        end else if (mode_en_i[0] && m_run_left != 0) begin
            m_run_left--; hit = 1;
        end
        sch = m_armed && (int'(shutter_i) != m_shut_prev);
        gch = m_armed && (int'(gain_i) != m_gain_prev);
        m_armed = 1; m_run_prev = mode_en_i[0];
        m_shut_prev = shutter_i; m_gain_prev = gain_i;
        m_upd = hit || (mode_en_i[1] && sch) || (mode_en_i[2] && gch) || mode_en_i[3];
        m_use = m_state; m_sum = 0; m_cnt = 0;
    endtask

    task automatic ob_pixels(int n, int level);
        for (int i = 0; i < n; i++) begin
            int v;
            @(negedge clk);
            frame_start_i = 0;
            v = level + int'($urandom_range(0, 7));
            if (v > 1023) v = 1023;
            pix_i = v[9:0]; pix_valid_i = 1; ob_flag_i = 1;
            if (m_cnt < OB_N) begin m_sum += v; m_cnt++; end
        end
    endtask

    task automatic act_pixels(int n, int fixed);
        for (int i = 0; i < n; i++) begin
            int v, e;
            @(negedge clk);
            frame_start_i = 0;
            v = (fixed >= 0) ? fixed : int'($urandom_range(0, 1023));
            pix_i = v[9:0]; pix_valid_i = 1; ob_flag_i = 0;
            e = expect_pix(v);
            @(posedge clk); #1;
            check(tag, int'(pix_valid_o), 1);
            check(tag, int'(pix_o), e);
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        frame_start_i = 0; pix_valid_i = 0; ob_flag_i = 0;
        frame_end_i = 1;
        if (m_upd && m_cnt >= OB_N) begin
            int nx;
            nx = filter_next(m_sum);
            m_old = m_sum >> 6;
            m_state = nx;
        end
        @(posedge clk); #1;
        check("R9", int'(pix_valid_o), 0);
        @(negedge clk);
        frame_end_i = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(int n_ob, int level, int n_act, int fixed);
        start_frame();
        ob_pixels(n_ob, level);
        act_pixels(n_act, fixed);
        end_frame();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R9: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(pix_valid_o), 0);
        check("R1", int'(pix_o), 0);
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        check("R1", int'(pix_valid_o), 0);

        // R11: compensation off, pedestal subtraction and clamp at zero
        tag = "R11"; mode_en_i = 0; offset_i = 8'd200;
        frame(OB_N, 300, 12, -1);
        act_pixels(0, -1);
        frame(20, 300, 4, 50);

        // R1: first compensated frame uses a zero estimate
        tag = "R1"; mode_en_i = 4'b1000; coef_a_i = 2'd1; coef_b_i = 2'd0; offset_i = 8'd10;
        frame(OB_N, 64, 8, -1);
        // R9: estimate from previous frame applies now
        tag = "R9";
        frame(OB_N, 64, 8, -1);
        // R8: every-frame updates with varying levels
        tag = "R8"; coef_b_i = 2'd1;
        frame(OB_N, 120, 8, -1);
        frame(OB_N, 40, 8, -1);

        // R2: short reference group, then overlong one
        tag = "R2";
        frame(500, 900, 8, -1);
        frame(8, 0, 8, -1);
        frame(OB_N + 80, 200, 8, -1);
        frame(8, 0, 8, -1);

        // R5: run mode for three frames
        tag = "R5"; mode_en_i = 4'b0001; run_len_i = 2'd2; coef_a_i = 2'd1; coef_b_i = 2'd0;
        for (int f = 0; f < 6; f++) frame(OB_N, 100 + 150 * f, 6, -1);

        // R6: shutter change detection
        tag = "R6"; mode_en_i = 4'b0010;
        frame(OB_N, 50, 6, -1);
        shutter_i = 13'd777;
        frame(OB_N, 300, 6, -1);
        frame(OB_N, 600, 6, -1);
        frame(8, 0, 6, -1);

        // R7: gain change detection
        tag = "R7"; mode_en_i = 4'b0100;
        frame(OB_N, 80, 6, -1);
        gain_i = 7'd33;
        frame(OB_N, 450, 6, -1);
        frame(OB_N, 20, 6, -1);
        frame(8, 0, 6, -1);

        // R4: OBold forced to OBnew versus stored
        tag = "R4"; mode_en_i = 4'b1000; coef_a_i = 2'd3; coef_b_i = 2'd2; ob_old_sel_i = 1;
        frame(OB_N, 500, 6, -1);
        frame(OB_N, 100, 6, -1);
        ob_old_sel_i = 0;
        frame(OB_N, 700, 6, -1);
        frame(8, 0, 6, -1);

        // R10: clamping at both ends and negative offset
        tag = "R10"; coef_a_i = 2'd1; coef_b_i = 2'd0; ob_old_sel_i = 1; offset_i = 8'h7F;
        frame(OB_N, 1000, 4, 1023);
        frame(OB_N, 1000, 4, 0);
        offset_i = 8'h85;
        frame(OB_N, 10, 6, -1);
        frame(8, 0, 4, 3);

        // R3: saturation with A=1/2, B=1
        tag = "R3"; coef_a_i = 2'd1; coef_b_i = 2'd3; offset_i = 8'd0;
        for (int f = 0; f < 3; f++) frame(OB_N, 1016, 4, 1023);

        // R3: random coefficients, levels and offsets
        for (int f = 0; f < 14; f++) begin
            coef_a_i = 2'($urandom_range(0, 3));
            coef_b_i = 2'($urandom_range(0, 3));
            ob_old_sel_i = 1'($urandom_range(0, 1));
            offset_i = 8'($urandom_range(0, 255));
            mode_en_i = 4'($urandom_range(1, 15));
            shutter_i = 13'($urandom_range(0, 3));
            gain_i = 7'($urandom_range(0, 3));
            run_len_i = 2'($urandom_range(0, 3));
            frame(OB_N, int'($urandom_range(0, 1016)), 10, -1);
        end

        summary();
        $finish;
    end
endmodule